// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This peripheral drives two independent pulse-width outputs. Each output spends a programmed number of prescaled ticks high, then a programmed number of prescaled ticks low, and repeats. There is no period register and no compare value. Each channel's waveform comes from a pair of tick counts packed into one 32-bit count word per channel.

Each channel picks one of four single-cycle strobe inputs as its tick source. It divides that source through its own 7-bit prescaler. The channel runs only while both its output enable and its prescaler gate are set. The prescaler, source-select, gate and enable fields of both channels share one control word. Software programs the block over a simple single-clock register bus. Any output inversion is left to software, which swaps the two counts.

A new count word is latched only when a high phase begins. A write in the middle of a period therefore never produces a truncated or glitched cycle.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset all three registers read zero and both PWM outputs are low.
- R2: Word offset 0x0 stores channel A's count word, 0x4 stores channel B's and 0x8 stores the control word; each read returns the stored 32-bit value, and a read of any other offset returns zero.
- R3: In a count word, bits 31:16 give the high-phase length and bits 15:0 the low-phase length, both in prescaled ticks; a running channel is high for exactly the high length, then low for exactly the low length, repeating.
- R4: A prescaler value N (control bits 14:8 for A, 22:16 for B) makes one prescaled tick from every N+1 strobes of the selected source.
- R5: Control bits 5:4 (A) and 7:6 (B) select which of the four tick_src bits, by index, feeds the channel's prescaler.
- R6: Control bit 0 (A) and bit 1 (B) enable the outputs; when clear the output is low and the channel's phase state and prescaler are cleared.
- R7: Control bit 15 (A) and bit 23 (B) gate the prescaler; when clear the output is low, exactly as with the enable clear.
- R8: A high length of zero gives a constant low output, whatever the low length.
- R9: A low length of zero with a nonzero high length gives a constant high output.
- R10: A count word written while a channel runs is applied only at the start of the next high phase; the phases already under way keep their old lengths.
- R11: The two channels run independently; programming or running one does not alter the other's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tick_src | input | 4 | Four single-cycle tick strobes, indexed by the source-select field |
| pwm_out | output | 2 | PWM outputs; bit 0 is channel A, bit 1 is channel B |

## Verification
The scoreboard measures each high and low run in strobes of the selected source. A design that ignores the prescaler, takes the wrong source index or drifts by one tick at a phase boundary therefore shows up as a wrong run length. The bench rewrites a count word in the middle of a high phase. A design that applies counts at once would cut that phase short or lengthen it. The zero-length cases are driven directly. Getting them wrong would produce a one-tick pulse or a stuck-in-phase output instead of a constant level. Clearing the enable and the gate separately catches a design that watches only one of the two bits.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 7;
    localparam int SEL_W      = 2;
    localparam int NSRC       = 1 << SEL_W;
    localparam int NCH        = 2;
    localparam int SEL_LSB    = 4;   // first source-select field
    localparam int DIV_LSB    = 8;   // first prescaler field
    localparam int DIV_STRIDE = 8;   // distance between channel prescaler fields

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             run_en;
        logic             gate_en;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } ch_cfg_t;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    output ch_cfg_t [NCH-1:0]           cfg_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH * 4);

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] cnt;
        logic [DATA_W-1:0]          ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr_i == ADDR_W'(c * 4)) r_d.cnt[c] = wdata_i;
            end
            if (addr_i == CTRL_ADDR) r_d.ctrl = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr_i == ADDR_W'(c * 4)) rdata_o = r_q.cnt[c];
        end
        if (addr_i == CTRL_ADDR) rdata_o = r_q.ctrl;
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            cfg_o[c].run_en  = r_q.ctrl[c];
            cfg_o[c].sel     = r_q.ctrl[SEL_LSB + SEL_W * c +: SEL_W];
            cfg_o[c].div     = r_q.ctrl[DIV_LSB + DIV_STRIDE * c +: DIV_W];
            cfg_o[c].gate_en = r_q.ctrl[DIV_LSB + DIV_STRIDE * c + DIV_W];
            cfg_o[c].hi      = r_q.cnt[c][DATA_W-1 -: CNT_W];
            cfg_o[c].lo      = r_q.cnt[c][CNT_W-1:0];
        end
    end

    // R2: a control write is held in the register on the following cycle
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == CTRL_ADDR) |=> r_q.ctrl == $past(wdata_i));
endmodule

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;
    logic strobe;

    always_comb begin
        strobe = src_i[sel_i];
        tick_o = active_i && strobe && (p_q.cnt >= div_i);
        p_d    = p_q;
        if (!active_i)   p_d.cnt = '0;
        else if (tick_o) p_d.cnt = '0;
        else if (strobe) p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R4: every prescaled tick restarts the strobe count
    assert_wrap_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> p_q.cnt == '0);
endmodule

// File: rtl/dpwm_phase_seq.sv
module dpwm_phase_seq
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             pwm_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi_sh;
        logic [CNT_W-1:0] lo_sh;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W:0] cnt_nx;

    function automatic seq_t start_period(input logic [CNT_W-1:0] hi,
                                          input logic [CNT_W-1:0] lo);
        seq_t s;
        s.hi_sh = hi;
        s.lo_sh = lo;
        s.cnt   = '0;
        s.ph    = (hi != '0) ? PH_HIGH : PH_LOW;
        return s;
    endfunction

    always_comb begin
        s_d    = s_q;
        cnt_nx = {1'b0, s_q.cnt} + 1'b1;
        if (!active_i) begin
            s_d = '0;
        end else begin
            unique case (s_q.ph)
                PH_IDLE: s_d = start_period(hi_i, lo_i);
                PH_HIGH: begin
                    if (tick_i) begin
                        if (cnt_nx >= {1'b0, s_q.hi_sh}) begin
                            if (s_q.lo_sh != '0) begin
                                s_d.ph  = PH_LOW;
                                s_d.cnt = '0;
                            end else begin
                                s_d = start_period(hi_i, lo_i);
                            end
                        end else begin
                            s_d.cnt = cnt_nx[CNT_W-1:0];
                        end
                    end
                end
                PH_LOW: begin
                    if (tick_i) begin
                        if (cnt_nx >= {1'b0, s_q.lo_sh}) s_d = start_period(hi_i, lo_i);
                        else                             s_d.cnt = cnt_nx[CNT_W-1:0];
                    end
                end
                default: s_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = (s_q.ph == PH_HIGH);

    // R6/R7: a stopped channel drives low on the next cycle
    assert_low_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !pwm_o);
    // R10: the level only moves on a tick, a start, or a stop
    assert_level_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !tick_i && s_q.ph != PH_IDLE) |=> $stable(pwm_o));
    // R3: the high phase never runs past its latched length
    assert_high_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HIGH) |-> (s_q.cnt < s_q.hi_sh));
    // R8: a latched zero high length never raises the output
    assert_zero_high_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && s_q.hi_sh == '0) |-> !pwm_o);
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import dpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        tick_src,
    output logic [1:0]        pwm_out
);
    ch_cfg_t [NCH-1:0] cfg;

    dpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic active;
        logic tick;

        assign active = cfg[c].run_en & cfg[c].gate_en;

        dpwm_prescaler u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active),
            .src_i    (tick_src),
            .sel_i    (cfg[c].sel),
            .div_i    (cfg[c].div),
            .tick_o   (tick)
        );

        dpwm_phase_seq u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active),
            .tick_i   (tick),
            .hi_i     (cfg[c].hi),
            .lo_i     (cfg[c].lo),
            .pwm_o    (pwm_out[c])
        );
    end
endmodule

// File: tb/dual_pwm_gen_bench.sv
module dual_pwm_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tick_src = '0;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // scoreboard state
    int    mon_ch = 0;
    int    mon_src = 0;
    bit    cur_lvl = 0;
    int    cur_len = 0;
    bit    exp_lvl[$];
    int    exp_len[$];
    string exp_req[$];

    dual_pwm_gen u_dual_pwm_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_src  (tick_src),
        .pwm_out   (pwm_out)
    );

    always #4 clk = ~clk;

    // strobe patterns: src0 every cycle, src1 every 3rd, src2 every 2nd, src3 every 5th
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            tick_src[0] = 1'b1;
            tick_src[1] = (cyc % 3 == 0);
            tick_src[2] = (cyc % 2 == 0);
            tick_src[3] = (cyc % 5 == 1);
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures runs in strobes of the watched source, pops expected runs
    initial begin
        forever begin
            @(negedge clk);
            if (pwm_out[mon_ch] != cur_lvl) begin
                if (exp_len.size() > 0) begin
                    bit    el;
                    int    en;
                    string er;
                    el = exp_lvl.pop_front();
                    en = exp_len.pop_front();
                    er = exp_req.pop_front();
                    check(el == cur_lvl, er, cur_lvl, el);
                    check(en == cur_len, er, cur_len, en);
                end
                cur_lvl = pwm_out[mon_ch];
                cur_len = 0;
            end
            if (tick_src[mon_src]) cur_len++;
        end
    end

    task automatic push_exp(input bit lvl, input int len, input string req);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_req.push_back(req);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === e, req, reg_rdata, e);
    endtask

    function automatic logic [31:0] ctl(input bit ea, input bit ga, input int da, input int sa,
                                        input bit eb, input bit gb, input int db, input int sb);
        logic [31:0] v;
        v = '0;
        v[0]     = ea;
        v[1]     = eb;
        v[5:4]   = 2'(sa);
        v[7:6]   = 2'(sb);
        v[14:8]  = 7'(da);
        v[15]    = ga;
        v[22:16] = 7'(db);
        v[23]    = gb;
        return v;
    endfunction

    task automatic wait_rise(input int ch);
        bit prev;
        prev = pwm_out[ch];
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
        #1;
    endtask

    task automatic wait_drain(input string req);
        int left;
        for (int i = 0; i < 20000 && exp_len.size() > 0; i++) @(negedge clk);
        left = exp_len.size();
        check(left == 0, req, left, 0);
        exp_lvl.delete(); exp_len.delete(); exp_req.delete();
    endtask

    task automatic hold_level(input int ch, input bit lvl, input int n, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);
        bus_read(4'h0, 32'h0, "R1 count A");
        bus_read(4'h4, 32'h0, "R1 count B");
        bus_read(4'h8, 32'h0, "R1 control");

        // R2: register map and readback
        bus_write(4'h0, 32'h0003_0005);
        bus_write(4'h4, 32'h0004_0002);
        bus_read(4'h0, 32'h0003_0005, "R2 count A");
        bus_read(4'h4, 32'h0004_0002, "R2 count B");
        bus_write(4'h8, 32'h00A5_5A00);
        bus_read(4'h8, 32'h00A5_5A00, "R2 control");
        bus_read(4'hC, 32'h0, "R2 unmapped");
        bus_write(4'h8, 32'h0);

        // R3: basic high/low lengths on A, source 0, no division
        mon_ch = 0; mon_src = 0;
        bus_write(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        wait_rise(0); wait_rise(0);
        push_exp(1, 3, "R3 high run"); push_exp(0, 5, "R3 low run");
        push_exp(1, 3, "R3 high run"); push_exp(0, 5, "R3 low run");
        wait_drain("R3 drain");
        check(pwm_out[1] == 1'b0, "R11 B idle while A runs", pwm_out[1], 0);

        // R4/R5: A with prescaler 2 from source 1
        bus_write(4'h0, 32'h0002_0004);
        mon_src = 1;
        bus_write(4'h8, ctl(1, 1, 2, 1, 0, 0, 0, 0));
        wait_rise(0); wait_rise(0);
        push_exp(1, 6, "R4 R5 high run"); push_exp(0, 12, "R4 R5 low run");
        push_exp(1, 6, "R4 R5 high run");
        wait_drain("R4 drain");

        // R5/R11: B with prescaler 1 from source 3, A still running
        mon_ch = 1; mon_src = 3;
        bus_write(4'h8, ctl(1, 1, 2, 1, 1, 1, 1, 3));
        wait_rise(1); wait_rise(1);
        push_exp(1, 8, "R11 B high run"); push_exp(0, 4, "R11 B low run");
        push_exp(1, 8, "R11 B high run");
        wait_drain("R11 drain B");
        mon_ch = 0; mon_src = 1;
        wait_rise(0);
        push_exp(1, 6, "R11 A high run"); push_exp(0, 12, "R11 A low run");
        wait_drain("R11 drain A");

        // R10: count change mid high phase applies from the next high phase
        bus_write(4'h0, 32'h0006_0004);
        mon_src = 0;
        bus_write(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        wait_rise(0); wait_rise(0);
        push_exp(1, 6, "R10 old high"); push_exp(0, 4, "R10 old low");
        push_exp(1, 2, "R10 new high"); push_exp(0, 3, "R10 new low");
        bus_write(4'h0, 32'h0002_0003);
        wait_drain("R10 drain");

        // R8: zero high length gives constant low
        bus_write(4'h0, 32'h0000_0004);
        settle(30);
        hold_level(0, 1'b0, 40, "R8 zero high");
        bus_write(4'h0, 32'h0000_0000);
        settle(10);
        hold_level(0, 1'b0, 40, "R8 both zero");

        // R9: zero low length gives constant high
        bus_write(4'h0, 32'h0005_0000);
        settle(20);
        hold_level(0, 1'b1, 40, "R9 zero low");

        // R6: enable clear forces low
        bus_write(4'h8, ctl(0, 1, 0, 0, 0, 0, 0, 0));
        settle(2);
        hold_level(0, 1'b0, 20, "R6 enable clear");

        // R7: gate clear forces low, then restoring it restarts
        bus_write(4'h8, ctl(1, 0, 0, 0, 0, 0, 0, 0));
        settle(2);
        hold_level(0, 1'b0, 20, "R7 gate clear");
        bus_write(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        settle(3);
        hold_level(0, 1'b1, 20, "R7 gate restored");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule